// File: doc/BRIEF.md
# Run-Time Loadable Sum-of-Products Array

This block is a small programmable logic array. Software or a sequencer loads its contents through a register-write port. There are two kinds of rows. An AND-plane row describes one product term. An OR-plane row says which product terms feed one output. Once every row has been written at least once, the block evaluates all outputs combinationally from the live inputs. Until then it holds every output at 0.

Each product term stores a 2-bit literal code for every input. This lets a term use an input true, use it complemented, or ignore it. In the default array mode, any term may be shared by any number of outputs. A separate mode input switches the block to a fenced mode. In that mode each output can see only its own fixed, disjoint group of terms. OR-plane bits outside that group are ignored, whatever was written. Every row can be read back through a separate combinational read port.

Top module: `pla_personality_eval`

## Requirements
- R1: After reset, every stored row reads back as 0, `cfg_valid` is 0 and `pla_out` is 0.
- R2: The literal code for input i sits at bits [2i+1:2i] of an AND-plane row. Code 00 leaves the input out of the term, 01 requires the input to be 1, and 10 requires it to be 0.
- R3: Literal code 11 makes its product term 0 for every input value. A term whose literals are all 00 evaluates to 1.
- R4: Bit t of an OR-plane row connects product term t into that output's OR. An output whose row is all zero evaluates to 0.
- R5: With `pal_mode` = 0, a term may feed any number of outputs. Loading the default personality gives F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A, where A, B and C are `pla_in` bits 0, 1 and 2.
- R6: With `pal_mode` = 1, output o sees only the terms t with t / PAL_GROUP = o (PAL_GROUP defaults to 4). Its OR-plane bits for other terms have no effect.
- R7: Rows 0 to N_TERM-1 are AND-plane rows and rows N_TERM to N_TERM+N_OUT-1 are OR-plane rows, one per output in order. A write takes effect at the clock edge where `cfg_we` is high. A write to a row number at or above N_TERM+N_OUT changes nothing.
- R8: The first write to each row marks it loaded. `cfg_valid` becomes 1 in the cycle after the last unloaded row is written, and it stays 1 through later rewrites until reset.
- R9: While `cfg_valid` is 0, `pla_out` is 0 whatever the inputs and stored rows are.
- R10: `cfg_rdata` shows the row chosen by `cfg_raddr` in the same cycle, zero-extended to the data width. It reads 0 for a row number out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Row write enable |
| cfg_addr | input | ADDR_W | Row number to write |
| cfg_wdata | input | DATA_W | Row contents to write |
| cfg_raddr | input | ADDR_W | Row number to read back |
| cfg_rdata | output | DATA_W | Read-back row contents |
| cfg_valid | output | 1 | All rows loaded |
| pal_mode | input | 1 | 1 selects fenced per-output term groups |
| pla_in | input | N_IN | Live logic inputs |
| pla_out | output | N_OUT | Sum-of-products results |

## Verification
`pla_out` and `cfg_rdata` are combinational. A change to `pla_in`, `pal_mode` or `cfg_raddr` is seen in the same cycle. A row write shows in both outputs from the edge that captures it, and `cfg_valid` rises on that same edge for the last missing row. The bench's driver changes inputs just after a rising edge, once the write has been captured. It pushes the expected value into a queue in that step. The monitor pops and compares at the next falling edge, so every expectation is sampled half a cycle after its stimulus settles.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_OMIT = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;

  // One literal of a product term: does the input value let the term through?
  function automatic logic lit_pass(input lit_code_e code, input logic x);
    case (code)
      LIT_OMIT: return 1'b1;
      LIT_TRUE: return x;
      LIT_COMP: return ~x;
      default:  return 1'b0;
    endcase
  endfunction

  // Fenced mode: term t belongs to output o when t / grp == o.
  function automatic bit in_group(input int t, input int o, input int grp);
    return (t / grp) == o;
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  input  logic [ADDR_W-1:0]        cfg_raddr,
  output logic [DATA_W-1:0]        cfg_rdata,
  output logic [N_TERM*2*N_IN-1:0] and_flat,
  output logic [N_OUT*N_TERM-1:0]  or_flat,
  output logic                     cfg_valid
);
  localparam int PW   = 2 * N_IN;
  localparam int ROWS = N_TERM + N_OUT;

  logic [ROWS-1:0] loaded_q;
  logic            addr_ok;
  logic [ROWS-1:0] wr_onehot;

  assign addr_ok   = {1'b0, cfg_addr} < (ADDR_W + 1)'(ROWS);
  assign wr_onehot = ROWS'(1) << cfg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      and_flat <= '0;
      or_flat  <= '0;
      loaded_q <= '0;
    end else if (cfg_we && addr_ok) begin
      for (int r = 0; r < N_TERM; r++)
        if (cfg_addr == ADDR_W'(r)) and_flat[r*PW +: PW] <= cfg_wdata[PW-1:0];
      for (int o = 0; o < N_OUT; o++)
        if (cfg_addr == ADDR_W'(N_TERM + o)) or_flat[o*N_TERM +: N_TERM] <= cfg_wdata[N_TERM-1:0];
      loaded_q <= loaded_q | wr_onehot;
    end
  end

  assign cfg_valid = &loaded_q;

  always_comb begin
    cfg_rdata = '0;
    for (int r = 0; r < N_TERM; r++)
      if (cfg_raddr == ADDR_W'(r)) cfg_rdata = DATA_W'(and_flat[r*PW +: PW]);
    for (int o = 0; o < N_OUT; o++)
      if (cfg_raddr == ADDR_W'(N_TERM + o)) cfg_rdata = DATA_W'(or_flat[o*N_TERM +: N_TERM]);
  end

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid);

  // R8
  mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ((loaded_q & $past(loaded_q)) == $past(loaded_q)));

  // R7
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !addr_ok) |=> ($stable(loaded_q) && $stable(and_flat) && $stable(or_flat)));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_TERM*2*N_IN-1:0] and_flat,
  input  logic [N_IN-1:0]          pla_in,
  output logic [N_TERM-1:0]        term_hit
);
  import pla_pkg::*;
  localparam int PW = 2 * N_IN;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] lit_ok;
    logic [N_IN-1:0] lit_killed;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit_ok[i]     = lit_pass(lit_code_e'(and_flat[t*PW + 2*i +: 2]), pla_in[i]);
      assign lit_killed[i] = and_flat[t*PW + 2*i] & and_flat[t*PW + 2*i + 1];
    end
    assign term_hit[t] = &lit_ok;

    // R3
    kill_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_hit[t] |-> (lit_killed == '0));
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM    = 5,
  parameter int N_OUT     = 4,
  parameter int PAL_GROUP = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_OUT*N_TERM-1:0] or_flat,
  input  logic [N_TERM-1:0]       term_hit,
  input  logic                    pal_mode,
  output logic [N_OUT-1:0]        or_raw
);
  import pla_pkg::*;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] grp_mask;
    logic [N_TERM-1:0] use_mask;
    for (genvar t = 0; t < N_TERM; t++) begin : g_bit
      localparam bit IN_GRP = in_group(t, o, PAL_GROUP);
      assign grp_mask[t] = IN_GRP;
      assign use_mask[t] = or_flat[o*N_TERM + t] & (~pal_mode | IN_GRP);
    end
    assign or_raw[o] = |(term_hit & use_mask);

    // R6
    pal_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pal_mode && ((term_hit & grp_mask) == '0)) |-> !or_raw[o]);
  end

endmodule

// File: rtl/pla_personality_eval.sv
module pla_personality_eval #(
  parameter int N_IN      = 3,
  parameter int N_TERM    = 5,
  parameter int N_OUT     = 4,
  parameter int PAL_GROUP = 4,
  parameter int ADDR_W    = $clog2(N_TERM + N_OUT),
  parameter int DATA_W    = (2 * N_IN > N_TERM) ? 2 * N_IN : N_TERM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_valid,
  input  logic              pal_mode,
  input  logic [N_IN-1:0]   pla_in,
  output logic [N_OUT-1:0]  pla_out
);
  logic [N_TERM*2*N_IN-1:0] and_flat;
  logic [N_OUT*N_TERM-1:0]  or_flat;
  logic [N_TERM-1:0]        term_hit;
  logic [N_OUT-1:0]         or_raw;

  pla_cfg_store #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .and_flat(and_flat), .or_flat(or_flat), .cfg_valid(cfg_valid)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk(clk), .rst_n(rst_n), .and_flat(and_flat), .pla_in(pla_in), .term_hit(term_hit)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .PAL_GROUP(PAL_GROUP)) u_or (
    .clk(clk), .rst_n(rst_n), .or_flat(or_flat), .term_hit(term_hit),
    .pal_mode(pal_mode), .or_raw(or_raw)
  );

  assign pla_out = cfg_valid ? or_raw : '0;

  // R9
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (pla_out == '0));

endmodule

// File: tb/tb_pla_personality_eval.sv
module tb_pla_personality_eval;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int         kind;   // 0 outputs, 1 readback, 2 valid flag
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [5:0] cfg_wdata = '0;
  logic [3:0] cfg_raddr = '0;
  logic [5:0] cfg_rdata;
  logic       cfg_valid;
  logic       pal_mode = 1'b0;
  logic [2:0] pla_in = '0;
  logic [3:0] pla_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_personality_eval dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .cfg_valid(cfg_valid), .pal_mode(pal_mode), .pla_in(pla_in), .pla_out(pla_out)
  );

  // reference equations, inputs given as a, b, c
  function automatic logic [3:0] ref_shared(input logic a, input logic b, input logic c);
    logic [3:0] f;
    f[0] = a | (!b && !c);
    f[1] = (a && !c) | (a && b);
    f[2] = (!b && !c) | (a && b);
    f[3] = (!b && c) | a;
    return f;
  endfunction

  function automatic logic [3:0] ref_fenced(input logic a, input logic b, input logic c);
    return {2'b00, (!b && c), a | (!b && !c)};
  endfunction

  task automatic wr(input logic [3:0] addr, input logic [5:0] data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic drive_out(input logic [2:0] x, input logic pal, input logic [3:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    pla_in = x; pal_mode = pal;
    it.kind = 0; it.exp = 8'(exp); it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drive_rd(input logic [3:0] addr, input logic [5:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    cfg_raddr = addr;
    it.kind = 1; it.exp = 8'(exp); it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic expect_valid(input logic exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.kind = 2; it.exp = 8'(exp); it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = 8'(pla_out);
        1:       act = 8'(cfg_rdata);
        default: act = 8'(cfg_valid);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_valid(1'b0, "R1 valid after reset");
    drive_out(3'b001, 1'b0, 4'b0000, "R1 outputs after reset");
    drive_rd(4'd0, 6'h00, "R1 row0 readback after reset");

    // default personality, leave the last OR row unloaded
    wr(4'd0, 6'h01);   // A
    wr(4'd1, 6'h28);   // B'C'
    wr(4'd2, 6'h21);   // AC'
    wr(4'd3, 6'h05);   // AB
    wr(4'd4, 6'h18);   // B'C
    wr(4'd5, 6'h03);
    wr(4'd6, 6'h0C);
    wr(4'd7, 6'h0A);
    wr(4'd9, 6'h3F);   // R7 out of range
    wr(4'd15, 6'h3F);  // R7 out of range
    expect_valid(1'b0, "R7 R8 valid with one row missing");
    drive_out(3'b001, 1'b0, 4'b0000, "R9 outputs held while unloaded");
    drive_rd(4'd9, 6'h00, "R10 out-of-range readback");
    drive_rd(4'd2, 6'h21, "R10 R7 AND row readback");

    wr(4'd8, 6'h11);
    expect_valid(1'b1, "R8 valid after last row");
    drive_rd(4'd8, 6'h11, "R10 OR row readback");
    for (int v = 0; v < 8; v++)
      drive_out(3'(v), 1'b0, ref_shared(v[0], v[1], v[2]), "R5 shared-term sweep");

    // R3 all-omit term is 1
    wr(4'd4, 6'h00);
    drive_out(3'b000, 1'b0, 4'b1101, "R3 all-omit term");
    expect_valid(1'b1, "R8 valid kept after rewrite");
    // R3 kill code on C
    wr(4'd4, 6'h38);
    drive_out(3'b000, 1'b0, 4'b0101, "R3 kill code term");
    // R2 complement literal on B only
    wr(4'd4, 6'h08);
    drive_out(3'b100, 1'b0, 4'b1000, "R2 complement literal B=0");
    drive_out(3'b010, 1'b0, 4'b0000, "R2 complement literal B=1");
    // R4 empty OR row
    wr(4'd6, 6'h00);
    drive_out(3'b011, 1'b0, 4'b1101, "R4 empty OR row");

    // R6 fenced mode, all OR bits set
    wr(4'd4, 6'h18);
    wr(4'd5, 6'h1F);
    wr(4'd6, 6'h1F);
    wr(4'd7, 6'h1F);
    wr(4'd8, 6'h1F);
    for (int v = 0; v < 8; v++)
      drive_out(3'(v), 1'b1, ref_fenced(v[0], v[1], v[2]), "R6 fenced sweep");
    drive_out(3'b100, 1'b0, 4'b1111, "R5 same rows shared mode B=0");
    drive_out(3'b010, 1'b0, 4'b0000, "R5 same rows shared mode B=1");
    drive_out(3'b100, 1'b1, 4'b0010, "R6 back to fenced mode");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule